// File: doc/BRIEF.md
# Addressable Latch with Decoder Mode

The block keeps eight one-bit storage cells and steers one data bit into the cell picked by a 3-bit address. Two active-low controls set the mode. One is an enable and the other is a clear. With the enable low and the clear high, the chosen cell follows the data bit. The cell keeps the value the data bit has when the enable returns high. With the enable high, every cell keeps its value. With the clear low and the enable high, every cell is wiped. With both low, the block is a one-of-eight decoder: every cell except the chosen one is wiped, and the chosen one follows the data bit.

Each channel models an inverting open-drain driver. A stored 1 turns the driver on, and the pin is pulled low. A stored 0 leaves the driver off, and the resolved pin level reads 1. The block runs on a free-running clock and samples both controls on every edge. It detects the enable's return to high from a registered copy of its previous value. It takes the address on the first cycle the enable is seen low and keeps that address until the enable goes high again, so one enable pulse writes one cell.

Top module: `addr_latch_decoder`

## Requirements
- R1: One cycle after a clock edge with `rst` high, every `pull_low` bit is 0 and every `pin_level` bit is 1.
- R2: On an edge with `en_n`=0 and `clr_n`=1, the selected cell takes `din`. Repeated edges of this kind make the cell follow `din`. The cell index is `addr`, with bit 0 as the least significant bit.
- R3: On the first edge with `en_n`=1 after edges with `en_n`=0, if `clr_n`=1, the selected cell stores the `din` present at that edge. It keeps that value afterwards.
- R4: In write mode, every cell other than the selected one keeps its contents.
- R5: On an edge with `en_n`=1 and `clr_n`=1 that does not follow a low enable, no cell changes. This holds whatever `din` and `addr` do.
- R6: On an edge with `en_n`=1 and `clr_n`=0, all cells become 0.
- R7: On an edge with `en_n`=0 and `clr_n`=0, all unselected cells become 0 and the selected cell takes `din`. At most one `pull_low` bit is then set.
- R8: The address is taken on the first edge at which `en_n` is seen low. Later `addr` changes are ignored until `en_n` has been high again.
- R9: Bit i of `pull_low` equals stored cell i, and `pin_level` is always the bitwise inverse of `pull_low`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, clears all cells |
| din | input | 1 | Data bit for the selected cell |
| addr | input | 3 | Cell index, bit 0 least significant |
| en_n | input | 1 | Active-low enable |
| clr_n | input | 1 | Active-low clear |
| pull_low | output | 8 | Per-channel driver on (pin pulled low) |
| pin_level | output | 8 | Resolved pin level, 1 when the driver is off |

## Verification
Every result comes from the cell registers, so the effect of inputs sampled at one rising edge appears at the outputs right after that edge and stays until the next edge. This applies to a write, a capture, a clear, a decode step and a reset. The bench drives inputs on the falling edge and advances a behavioural model at the rising edge. It compares both output vectors on the following falling edge, so each check falls in the single cycle in which its result is due.

// File: rtl/adl_pkg.sv
package adl_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD   = 2'd0,
        MODE_WRITE  = 2'd1,
        MODE_CLEAR  = 2'd2,
        MODE_DECODE = 2'd3
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  capture;
    } ctrl_t;

    function automatic mode_e pick_mode(input logic en_n, input logic clr_n);
        mode_e m;
        case ({en_n, clr_n})
            2'b01:   m = MODE_WRITE;
            2'b00:   m = MODE_DECODE;
            2'b10:   m = MODE_CLEAR;
            default: m = MODE_HOLD;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/adl_ctrl.sv
module adl_ctrl
    import adl_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_n,
    input  logic              clr_n,
    input  logic [ADDR_W-1:0] addr_in,
    output ctrl_t             ctrl,
    output logic [ADDR_W-1:0] sel_addr
);

    logic              en_prev;
    logic [ADDR_W-1:0] addr_hold;
    logic              first_low;

    assign first_low    = !en_n && en_prev;
    assign sel_addr     = first_low ? addr_in : addr_hold;
    assign ctrl.mode    = pick_mode(en_n, clr_n);
    assign ctrl.capture = en_n && !en_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_prev   <= 1'b1;
            addr_hold <= '0;
        end else begin
            en_prev <= en_n;
            if (first_low) begin
                addr_hold <= addr_in;
            end
        end
    end

endmodule

// File: rtl/adl_bank.sv
module adl_bank
    import adl_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int NCELL  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [ADDR_W-1:0] sel_addr,
    input  logic              din,
    output logic [NCELL-1:0]  state_q
);

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        logic hit;
        assign hit = (sel_addr == ADDR_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                state_q[i] <= 1'b0;
            end else begin
                case (ctrl.mode)
                    MODE_WRITE:  if (hit) state_q[i] <= din;
                    MODE_DECODE: state_q[i] <= hit ? din : 1'b0;
                    MODE_CLEAR:  state_q[i] <= 1'b0;
                    default:     if (hit && ctrl.capture) state_q[i] <= din;
                endcase
            end
        end
    end

endmodule

// File: rtl/adl_drive.sv
module adl_drive #(
    parameter int NCELL = 8
) (
    input  logic [NCELL-1:0] state_q,
    output logic [NCELL-1:0] pull_low,
    output logic [NCELL-1:0] pin_level
);

    for (genvar i = 0; i < NCELL; i++) begin : g_drv
        assign pull_low[i]  = state_q[i];
        assign pin_level[i] = state_q[i] ? 1'b0 : 1'b1;
    end

endmodule

// File: rtl/addr_latch_decoder.sv
module addr_latch_decoder
    import adl_pkg::*;
#(
    parameter  int ADDR_W = 3,
    localparam int NCELL  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    input  logic [ADDR_W-1:0] addr,
    input  logic              en_n,
    input  logic              clr_n,
    output logic [NCELL-1:0]  pull_low,
    output logic [NCELL-1:0]  pin_level
);

    ctrl_t             ctrl;
    logic [ADDR_W-1:0] sel_addr;
    logic [NCELL-1:0]  state_q;

    adl_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .en_n     (en_n),
        .clr_n    (clr_n),
        .addr_in  (addr),
        .ctrl     (ctrl),
        .sel_addr (sel_addr)
    );

    adl_bank #(.ADDR_W(ADDR_W), .NCELL(NCELL)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl),
        .sel_addr (sel_addr),
        .din      (din),
        .state_q  (state_q)
    );

    adl_drive #(.NCELL(NCELL)) u_drive (
        .state_q   (state_q),
        .pull_low  (pull_low),
        .pin_level (pin_level)
    );

endmodule

// File: rtl/adl_checker.sv
module adl_checker #(
    parameter int NCELL = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             en_n,
    input logic             clr_n,
    input logic [NCELL-1:0] pull_low,
    input logic [NCELL-1:0] pin_level
);

    logic en_seen = 1'b1;
    logic rst_d   = 1'b0;

    always_ff @(posedge clk) begin
        rst_d   <= rst;
        en_seen <= rst ? 1'b1 : en_n;
    end

    // R1: cells are cleared the cycle after reset
    always_ff @(posedge clk) begin
        if (rst_d) begin
            a_r1_reset_clear: assert (pull_low == '0);
        end
    end

    a_r9_pin_inverse: assert property (@(posedge clk) disable iff (rst)
        pin_level == ~pull_low);

    a_r6_clear_all: assert property (@(posedge clk) disable iff (rst)
        (en_n && !clr_n) |=> (pull_low == '0));

    a_r5_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (en_n && clr_n && en_seen) |=> $stable(pull_low));

    a_r7_decode_onehot: assert property (@(posedge clk) disable iff (rst)
        (!en_n && !clr_n) |=> $onehot0(pull_low));

    a_r4_single_cell: assert property (@(posedge clk) disable iff (rst)
        (!en_n && clr_n) |=> ($countones(pull_low ^ $past(pull_low)) <= 1));

endmodule

bind addr_latch_decoder adl_checker #(.NCELL(NCELL)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en_n      (en_n),
    .clr_n     (clr_n),
    .pull_low  (pull_low),
    .pin_level (pin_level)
);

// File: tb/sim_addr_latch_decoder.sv
module sim_addr_latch_decoder;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0;
    logic [2:0] addr = 3'd0;
    logic       en_n = 1'b1;
    logic       clr_n = 1'b1;
    logic [7:0] pull_low;
    logic [7:0] pin_level;

    int errors = 0;
    int checks = 0;
    int model[8];
    int lat_a = 0;
    int prev_en = 1;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_latch_decoder u0 (
        .clk(clk), .rst(rst), .din(din), .addr(addr),
        .en_n(en_n), .clr_n(clr_n),
        .pull_low(pull_low), .pin_level(pin_level)
    );

    function automatic logic [7:0] exp_vec();
        logic [7:0] v = '0;
        for (int i = 0; i < 8; i++) v[i] = (model[i] != 0);
        return v;
    endfunction

    task automatic model_edge();
        int ea;
        bit first;
        if (rst) begin
            for (int i = 0; i < 8; i++) model[i] = 0;
            prev_en = 1;
            lat_a = 0;
            return;
        end
        first = (en_n == 0) && (prev_en == 1);
        ea = first ? int'(addr) : lat_a;
        if (first) lat_a = int'(addr);
        if (!en_n && clr_n) begin
            model[ea] = din;
        end else if (!en_n && !clr_n) begin
            for (int i = 0; i < 8; i++) model[i] = 0;
            model[ea] = din;
        end else if (en_n && !clr_n) begin
            for (int i = 0; i < 8; i++) model[i] = 0;
        end else if (prev_en == 0) begin
            model[ea] = din;
        end
        prev_en = en_n;
    endtask

    task automatic compare(input string tag);
        logic [7:0] e = exp_vec();
        checks++;
        if (pull_low !== e) begin
            errors++;
            $display("FAIL %s pull_low actual=%b expected=%b", tag, pull_low, e);
        end
        checks++;
        if (pin_level !== ~e) begin
            errors++;
            $display("FAIL R9 pin_level actual=%b expected=%b", pin_level, ~e);
        end
    endtask

    // drive at falling edge, model at rising edge, compare at next falling edge
    task automatic step(input logic d, input int a, input logic en, input logic clr,
                        input string tag);
        din = d; addr = 3'(a); en_n = en; clr_n = clr;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic reset_cycle();
        rst = 1'b1;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        rst = 1'b0;
        compare("R1");
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        reset_cycle();
        reset_cycle();

        // R2: write and follow
        step(1, 5, 0, 1, "R2");
        step(0, 5, 0, 1, "R2");
        step(1, 5, 0, 1, "R2");
        // R3: capture at rising enable
        step(1, 5, 1, 1, "R3");
        // R5: hold with data and address changing
        step(0, 2, 1, 1, "R5");
        step(1, 7, 1, 1, "R5");
        step(0, 5, 1, 1, "R5");
        // R8: address latched on first low, change ignored
        step(1, 2, 0, 1, "R8");
        step(1, 6, 0, 1, "R8");
        step(0, 6, 0, 1, "R8");
        step(1, 6, 1, 1, "R8");
        // R3: edge value 0 differs from earlier low-phase value
        step(1, 3, 0, 1, "R3");
        step(0, 3, 1, 1, "R3");
        // R4: write every address in turn
        for (int k = 0; k < 8; k++) begin
            step(k[0] ^ k[2], k, 0, 1, "R4");
            step(k[0] ^ k[2], k, 1, 1, "R4");
            step(1, 7 - k, 1, 1, "R5");
        end
        // R6: clear all
        step(1, 0, 1, 0, "R6");
        step(1, 3, 1, 1, "R5");
        // R7: decoder mode
        for (int k = 0; k < 8; k++) begin
            step(1, k, 0, 0, "R7");
            step(0, k, 0, 0, "R7");
            step(1, (k + 3) % 8, 0, 0, "R7");
            step(1, k, 1, 1, "R7");
        end
        // R6: clear after decode, then write without reset
        step(0, 0, 1, 0, "R6");
        step(1, 1, 0, 1, "R2");
        step(1, 1, 1, 1, "R3");
        // R1: reset clears stored data
        reset_cycle();
        step(0, 4, 1, 1, "R5");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule